// File: doc/BRIEF.md
# Single-Bit Hamming Corrector for a 512-Byte Sector

This block takes two 24-bit check codes for one 512-byte sector: the code kept in flash and the code freshly generated over the data as it was read. It XORs them into a 24-bit syndrome, made of three syndrome bytes. Byte 0 sits in bits 7:0 and byte 2 in bits 23:16. The block then sorts the outcome into one of five verdicts. When the syndrome points at one flipped data bit, the block repairs that bit in the sector buffer. It does this through a byte-wide port with one cycle of read latency, using one read, one XOR and one write.

A host loads the two codes and the blank-page policy bit, then pulses `start`. A one-cycle `done` pulse marks the result. The 3-bit `status` keeps its value until the next result. Producing the check codes is handled elsewhere.

Top module: `hecc_fix`

## Requirements
- R1: While reset is active and right after it, `done` is 0, `status` is 0, and neither `buf_rd_en` nor `buf_wr_en` is asserted.
- R2: A zero syndrome gives status 0 (clean). It wins over every other test, the blank-page test included. Any verdict other than 2 leaves the buffer untouched, and its `done` comes exactly two cycles after the cycle in which `start` was sampled high.
- R3: If `skip_blank` is 1, the stored code is 0xFFFFFF and the syndrome is not zero, the status is 1 (blank page). This holds even when the syndrome would otherwise be correctable.
- R4: Correction needs every syndrome byte d to pass ((d ^ (d >> 1)) & 0x55) == 0x55, meaning each bit pair has exactly one bit set. Such a syndrome gives status 2 (data corrected).
- R5: The 9-bit byte index, from its MSB to its LSB, is formed from d2[1], then d1 bits 7, 5, 3 and 1, then d0 bits 7, 5, 3 and 1.
- R6: The 3-bit bit index is {d2[7], d2[5], d2[3]}, with d2[3] as its LSB.
- R7: A correction proceeds in this order:
  - `buf_rd_en` is high two cycles after `start` is sampled, with `buf_addr` set to the byte index.
  - `buf_wr_en` is high two cycles later, at the same address, with `buf_wdata` = read byte XOR (1 << bit index).
  - `done` follows in the next cycle.
- R8: A syndrome that fails the pair test and has exactly one bit set gives status 3 (fault in stored code). No buffer access takes place.
- R9: Any other non-zero syndrome gives status 4 (uncorrectable).
- R10: A `start` that arrives while a correction is in progress is ignored. It produces no extra `done` and no extra buffer access.
- R11: `done` is high for exactly one cycle per accepted start, and `status` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check; sampled only when idle |
| stored_code | input | 24 | Check code read back from flash |
| calc_code | input | 24 | Check code computed over the data just read |
| skip_blank | input | 1 | Treat an all-ones stored code as an unprotected page |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after `buf_rd_en` |
| buf_addr | output | 9 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle result pulse |
| status | output | 3 | 0 clean, 1 blank, 2 data fixed, 3 code fault, 4 uncorrectable |

## Verification
Two tests can succeed on the same input: the blank-page test and the correction test. This happens when the stored code is all ones and the calculated code is 0xAAAAAA, because the resulting syndrome of 0x555555 is a valid single-bit pattern.

The bench applies this pair twice:
- With `skip_blank` set, it expects status 1, a latency of two cycles, no buffer write and byte 0 unchanged.
- With the flag clear, it expects status 2 and bit 0 of byte 0 flipped.

A zero syndrome with an all-ones stored code checks that the clean verdict takes priority over the blank verdict.

// File: rtl/hecc_fix_pkg.sv
package hecc_fix_pkg;
    localparam int CODE_BYTES = 3;
    localparam int CODE_W     = 8 * CODE_BYTES;
    localparam int DATA_W     = 8;
    localparam int BIT_W      = $clog2(DATA_W);
    localparam int ADDR_W     = 9;
    localparam int SECT_BYTES = 1 << ADDR_W;

    typedef enum logic [2:0] {
        ST_CLEAN    = 3'd0,
        ST_BLANK    = 3'd1,
        ST_FIX_DATA = 3'd2,
        ST_FIX_CODE = 3'd3,
        ST_UNCORR   = 3'd4
    } fix_status_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_EVAL,
        SQ_READ,
        SQ_WAIT,
        SQ_WRITE
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] byte_idx;
        logic [BIT_W-1:0]  bit_idx;
    } err_loc_t;
endpackage

// File: rtl/hecc_syn_classify.sv
module hecc_syn_classify
    import hecc_fix_pkg::*;
(
    input  logic [CODE_W-1:0] syn,
    input  logic              blank_hit,
    output fix_status_e       verdict
);
    logic [CODE_BYTES-1:0] pair_ok;
    logic                  one_hot;

    // Each syndrome byte must show exactly one set bit in every bit pair.
    for (genvar g = 0; g < CODE_BYTES; g++) begin : g_pair
        logic [7:0] d_b;
        assign d_b        = syn[8*g +: 8];
        assign pair_ok[g] = ((d_b ^ (d_b >> 1)) & 8'h55) == 8'h55;
    end

    assign one_hot = (syn & (syn - CODE_W'(1))) == '0;

    always_comb begin
        if (syn == '0)
            verdict = ST_CLEAN;
        else if (blank_hit)
            verdict = ST_BLANK;
        else if (&pair_ok)
            verdict = ST_FIX_DATA;
        else if (one_hot)
            verdict = ST_FIX_CODE;
        else
            verdict = ST_UNCORR;
    end
endmodule

// File: rtl/hecc_err_locate.sv
module hecc_err_locate
    import hecc_fix_pkg::*;
(
    input  logic [CODE_W-1:0] syn,
    output err_loc_t          loc
);
    localparam int LOW_BITS = 8;          // byte index bits taken from d0 and d1
    localparam int PER_BYTE = 4;          // odd bits per syndrome byte
    localparam int D2_BASE  = 16;

    logic [ADDR_W-1:0] bidx;
    logic [BIT_W-1:0]  bsel;

    // Odd bits of d0, then d1, give the low byte-index bits, LSB first.
    for (genvar i = 0; i < LOW_BITS; i++) begin : g_byte
        assign bidx[i] = syn[(i / PER_BYTE) * 8 + 2 * (i % PER_BYTE) + 1];
    end
    assign bidx[ADDR_W-1] = syn[D2_BASE + 1];

    // Bit index uses the odd bits of d2 above bit 1.
    for (genvar j = 0; j < BIT_W; j++) begin : g_bit
        assign bsel[j] = syn[D2_BASE + 2 * j + 3];
    end

    assign loc = {bidx, bsel};
endmodule

// File: rtl/hecc_rmw_seq.sv
module hecc_rmw_seq
    import hecc_fix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    input  logic              skip_blank,
    input  fix_status_e       verdict,
    input  err_loc_t          loc,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [CODE_W-1:0] syn_o,
    output logic              blank_o,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              done,
    output fix_status_e       status
);
    typedef struct packed {
        seq_state_e        state;
        logic [CODE_W-1:0] syn;
        logic              blank;
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bsel;
        logic              rd_en;
        logic              wr_en;
        logic [DATA_W-1:0] wdata;
        logic              done;
        fix_status_e       status;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        state:  SQ_IDLE,
        syn:    '0,
        blank:  1'b0,
        addr:   '0,
        bsel:   '0,
        rd_en:  1'b0,
        wr_en:  1'b0,
        wdata:  '0,
        done:   1'b0,
        status: ST_CLEAN
    };

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.rd_en = 1'b0;
        r_d.wr_en = 1'b0;
        r_d.done  = 1'b0;
        case (r_q.state)
            SQ_IDLE: begin
                if (start) begin
                    r_d.syn   = stored_code ^ calc_code;
                    r_d.blank = skip_blank && (&stored_code);
                    r_d.state = SQ_EVAL;
                end
            end
            SQ_EVAL: begin
                if (verdict == ST_FIX_DATA) begin
                    r_d.addr  = loc.byte_idx;
                    r_d.bsel  = loc.bit_idx;
                    r_d.rd_en = 1'b1;
                    r_d.state = SQ_READ;
                end else begin
                    r_d.done   = 1'b1;
                    r_d.status = verdict;
                    r_d.state  = SQ_IDLE;
                end
            end
            SQ_READ: begin
                r_d.state = SQ_WAIT;
            end
            SQ_WAIT: begin
                r_d.wr_en = 1'b1;
                r_d.wdata = buf_rdata ^ (DATA_W'(1) << r_q.bsel);
                r_d.state = SQ_WRITE;
            end
            SQ_WRITE: begin
                r_d.done   = 1'b1;
                r_d.status = ST_FIX_DATA;
                r_d.state  = SQ_IDLE;
            end
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign syn_o     = r_q.syn;
    assign blank_o   = r_q.blank;
    assign buf_addr  = r_q.addr;
    assign buf_rd_en = r_q.rd_en;
    assign buf_wr_en = r_q.wr_en;
    assign buf_wdata = r_q.wdata;
    assign done      = r_q.done;
    assign status    = r_q.status;
endmodule

// File: rtl/hecc_fix.sv
module hecc_fix
    import hecc_fix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    input  logic              skip_blank,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              done,
    output logic [2:0]        status
);
    logic [CODE_W-1:0] syn_q;
    logic              blank_q;
    fix_status_e       verdict;
    fix_status_e       status_e;
    err_loc_t          loc;

    hecc_syn_classify u_class (
        .syn       (syn_q),
        .blank_hit (blank_q),
        .verdict   (verdict)
    );

    hecc_err_locate u_loc (
        .syn (syn_q),
        .loc (loc)
    );

    hecc_rmw_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .skip_blank  (skip_blank),
        .verdict     (verdict),
        .loc         (loc),
        .buf_rdata   (buf_rdata),
        .syn_o       (syn_q),
        .blank_o     (blank_q),
        .buf_addr    (buf_addr),
        .buf_rd_en   (buf_rd_en),
        .buf_wr_en   (buf_wr_en),
        .buf_wdata   (buf_wdata),
        .done        (done),
        .status      (status_e)
    );

    assign status = status_e;
endmodule

// File: rtl/hecc_fix_chk.sv
module hecc_fix_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       buf_rd_en,
    input logic       buf_wr_en,
    input logic [8:0] buf_addr,
    input logic       done,
    input logic [2:0] status
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R11
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));  // R7
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en, 2));  // R7
    AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> buf_addr == $past(buf_addr, 2));  // R5
    AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(buf_wr_en) |-> (done && status == 3'd2));  // R7
    AST_NONFIX_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 3'd2) |-> (!$past(buf_rd_en) && !$past(buf_wr_en)));  // R2
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status <= 3'd4);  // R9
endmodule

bind hecc_fix hecc_fix_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_rd_en (buf_rd_en),
    .buf_wr_en (buf_wr_en),
    .buf_addr  (buf_addr),
    .done      (done),
    .status    (status)
);

// File: tb/sim_hecc_fix.sv
module sim_hecc_fix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        skip_blank = 1'b0;
    logic [7:0]  buf_rdata = '0;
    logic [8:0]  buf_addr;
    logic        buf_rd_en, buf_wr_en, done;
    logic [7:0]  buf_wdata;
    logic [2:0]  status;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] mem    [0:511];
    logic [7:0] shadow [0:511];
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
    logic [8:0] last_wr = '0;

    always #4 clk = ~clk;

    hecc_fix u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored_code),
        .calc_code(calc_code), .skip_blank(skip_blank), .buf_rdata(buf_rdata),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
        .buf_wdata(buf_wdata), .done(done), .status(status)
    );

    // Buffer model: one cycle read latency.
    always @(posedge clk) begin
        if (buf_rd_en) begin
            buf_rdata <= mem[buf_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (buf_wr_en) begin
            mem[buf_addr] <= buf_wdata;
            wr_cnt <= wr_cnt + 1;
            last_wr <= buf_addr;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    // {stored, calc, skip, status, byte index, bit index}
    localparam int NV = 13;
    localparam logic [63:0] VECS [0:NV-1] = '{
        {24'h3C3C3C, 24'h3C3C3C, 1'b0, 3'd0, 9'd0,   3'd0},  // R2
        {24'h476103, 24'h123456, 1'b0, 3'd2, 9'd0,   3'd0},  // R4 R5 R6
        {24'hAAAAAA, 24'h000000, 1'b0, 3'd2, 9'd511, 3'd7},  // R5 R6
        {24'h969669, 24'h0F0F0F, 1'b1, 3'd2, 9'd165, 3'd5},  // R5 R6
        {24'h665555, 24'h000000, 1'b0, 3'd2, 9'd256, 3'd2},  // R5 R6
        {24'hFFFFFF, 24'h000000, 1'b1, 3'd1, 9'd0,   3'd0},  // R3
        {24'hFFFFFF, 24'hAAAAAA, 1'b1, 3'd1, 9'd0,   3'd0},  // R3 over correctable
        {24'hFFFFFF, 24'hAAAAAA, 1'b0, 3'd2, 9'd0,   3'd0},  // R4
        {24'h000800, 24'h000000, 1'b0, 3'd3, 9'd0,   3'd0},  // R8
        {24'h000001, 24'h000000, 1'b0, 3'd3, 9'd0,   3'd0},  // R8
        {24'h000003, 24'h000000, 1'b0, 3'd4, 9'd0,   3'd0},  // R9
        {24'hFFFFFF, 24'h000000, 1'b0, 3'd4, 9'd0,   3'd0},  // R9
        {24'hFFFFFF, 24'hFFFFFF, 1'b1, 3'd0, 9'd0,   3'd0}   // R2 over blank
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic run(input logic [23:0] s, input logic [23:0] c, input logic sk,
                       input int hold, output int lat);
        @(negedge clk);
        stored_code = s; calc_code = c; skip_blank = sk; start = 1'b1;
        for (int k = 0; k < hold; k++) @(negedge clk);
        start = 1'b0;
        lat = hold;
        while (!done && lat < 30) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0 && buf_rd_en == 1'b0 && buf_wr_en == 1'b0, "R1 strobes", int'(done), 0);
        check(status == 3'd0, "R1 status", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && status == 3'd0, "R1 after release", int'(status), 0);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] s, c;
            logic        sk;
            logic [2:0]  es, eb;
            logic [8:0]  ea;
            int          lat, w0, r0, d0;
            logic [7:0]  expb;
            {s, c, sk, es, ea, eb} = VECS[v];
            w0 = wr_cnt; r0 = rd_cnt; d0 = done_cnt;
            run(s, c, sk, 1, lat);
            if (es == 3'd2) begin
                check(status == es, "R4 status", int'(status), int'(es));
                check(lat == 5, "R7 latency", lat, 5);
                check(wr_cnt == w0 + 1 && rd_cnt == r0 + 1, "R7 one rmw", wr_cnt - w0, 1);
                check(last_wr == ea, "R5 byte index", int'(last_wr), int'(ea));
                expb = shadow[ea] ^ (8'd1 << eb);
                check(mem[ea] == expb, "R6 bit flipped", int'(mem[ea]), int'(expb));
                shadow[ea] = expb;
            end else begin
                case (es)
                    3'd0: check(status == es, "R2 status", int'(status), int'(es));
                    3'd1: check(status == es, "R3 status", int'(status), int'(es));
                    3'd3: check(status == es, "R8 status", int'(status), int'(es));
                    default: check(status == es, "R9 status", int'(status), int'(es));
                endcase
                check(lat == 2, "R2 latency", lat, 2);
                check(wr_cnt == w0 && rd_cnt == r0, "R2 no access", wr_cnt - w0, 0);
                check(mem[0] == shadow[0], "R3 byte0 untouched", int'(mem[0]), int'(shadow[0]));
            end
            @(negedge clk);
            check(done == 1'b0, "R11 pulse width", int'(done), 0);
            check(status == es, "R11 status held", int'(status), int'(es));
            check(done_cnt == d0 + 1, "R11 one done", done_cnt - d0, 1);
        end

        // R10: start held high through the busy period of a correction
        begin
            int lat, w0, d0;
            logic [7:0] expb;
            w0 = wr_cnt; d0 = done_cnt;
            run(24'h555555, 24'h000000, 1'b0, 3, lat);
            repeat (10) @(negedge clk);
            check(done_cnt == d0 + 1, "R10 single done", done_cnt - d0, 1);
            check(wr_cnt == w0 + 1, "R10 single write", wr_cnt - w0, 1);
            expb = shadow[0] ^ 8'h01;
            check(mem[0] == expb, "R10 byte0", int'(mem[0]), int'(expb));
            check(status == 3'd2, "R10 status", int'(status), 2);
            shadow[0] = expb;
        end
        report();
    end
endmodule